// File: doc/BRIEF.md
# Externally Clocked Triggered Counter

A counter whose start and whose pace come from two different pins. A trigger pin, the channel input, arms the counter. A separate external clock pin supplies the edges that it counts. Both pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, an edge detector and a registered edge pulse. As a result, anything seen on either pin takes effect three system-clock cycles after the first system edge that samples it.

In trigger slave mode the counter stays idle until a qualified trigger edge arrives. That edge sets the counter-enable status and a sticky trigger flag together. From then on the count advances on external clock edges, divided by a selectable prescaler. It can instead advance on every system clock when the external clock is switched off. In any other slave mode the enable status simply follows a run control. A debug-freeze option holds the count while a halt input is raised. All controls are plain ports.

Top module: `ext_trig_counter`

## Requirements
- R1: After reset the count is 0, the enable status is 0 and the trigger flag is 0.
- R2: With slave mode 3'b110 the count stays put until a trigger edge. A trigger edge on the channel input sampled at system edge k sets both the enable status and the trigger flag at edge k+3.
- R3: Only trigger select 3'b101 routes channel input edges to the trigger. With any other select value, channel edges change neither the enable status nor the flag.
- R4: Trigger polarity 0 qualifies rising channel edges, and polarity 1 qualifies falling ones. An edge of the other direction is ignored.
- R5: Once enabled in slave mode 3'b110, the counter stays enabled through later trigger edges, as long as the mode is unchanged.
- R6: With the external clock enabled, each qualified external edge advances an enabled count by one, three system cycles after it is sampled. External polarity 0 counts rising edges and 1 counts falling edges. Without external edges the count holds.
- R7: The 2-bit external prescaler divides qualified external edges by 1, 2, 4 and 8 for values 0, 1, 2 and 3.
- R8: With the external clock disabled, an enabled counter advances on every system clock.
- R9: In any slave mode other than 3'b110, the enable status takes the value of the run input one cycle later.
- R10: While both the debug-halt input and the debug-stop enable are 1, the count holds. With the stop enable at 0, the halt input has no effect.
- R11: The trigger flag stays set until a one-cycle clear pulse. A clear in the same cycle as a new trigger leaves the flag set.
- R12: The count wraps from 0xFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| ch1_i | input | 1 | Asynchronous channel input used as trigger |
| ext_clk_en | input | 1 | 1: count external edges, 0: count system clocks |
| ext_pol | input | 1 | External edge polarity (0 rising, 1 falling) |
| ext_psc | input | 2 | External edge prescaler (divide by 1, 2, 4, 8) |
| trig_sel | input | 3 | Trigger source select (3'b101 = channel input) |
| trig_pol | input | 1 | Trigger edge polarity (0 rising, 1 falling) |
| slave_mode | input | 3 | Slave mode (3'b110 = trigger mode) |
| run_i | input | 1 | Counter enable outside trigger mode |
| dbg_halt | input | 1 | Debug halt indication |
| dbg_stop_en | input | 1 | Freeze the count while halted |
| flag_clr | input | 1 | One-cycle clear of the trigger flag |
| count_o | output | 16 | Counter value |
| cnt_en_o | output | 1 | Counter-enable status |
| trig_flag_o | output | 1 | Sticky trigger flag |

## Verification
The bench targets the exact latency from pin to effect. If a synchronizer stage were missing or added, the enable, the flag and the count would change one cycle early or late against the reference model. A design that ignored the select, or inverted a polarity, would enable on rejected edges or miss qualified ones. A wrong prescaler mask would leave the count after sixteen pulses at a value other than 16, 8, 4 or 2. The bench also lines a clear pulse up with the exact cycle a trigger lands, to catch a clear-over-set priority. It runs the count past 0xFFFF to catch a wrong width or a saturating counter.

// File: rtl/ext_trig_counter.sv
module ext_trig_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic             ch1_i,
  input  logic             ext_clk_en,
  input  logic             ext_pol,
  input  logic [1:0]       ext_psc,
  input  logic [2:0]       trig_sel,
  input  logic             trig_pol,
  input  logic [2:0]       slave_mode,
  input  logic             run_i,
  input  logic             dbg_halt,
  input  logic             dbg_stop_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             cnt_en_o,
  output logic             trig_flag_o
);
  localparam logic [2:0] MODE_TRIG = 3'b110;
  localparam logic [2:0] SRC_CH1   = 3'b101;

  logic [1:0] ext_sync, ch_sync;
  logic       ext_prev, ch_prev;
  logic       ext_edge_q, trig_q;
  logic [2:0] pcnt;

  // synchronize, detect, register the edge pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync   <= '0;
      ch_sync    <= '0;
      ext_prev   <= 1'b0;
      ch_prev    <= 1'b0;
      ext_edge_q <= 1'b0;
      trig_q     <= 1'b0;
    end else begin
      ext_sync   <= {ext_sync[0], ext_clk_i};
      ch_sync    <= {ch_sync[0], ch1_i};
      ext_prev   <= ext_sync[1];
      ch_prev    <= ch_sync[1];
      ext_edge_q <= ext_pol ? (~ext_sync[1] & ext_prev) : (ext_sync[1] & ~ext_prev);
      trig_q     <= (trig_sel == SRC_CH1) &
                    (trig_pol ? (~ch_sync[1] & ch_prev) : (ch_sync[1] & ~ch_prev));
    end
  end

  wire [2:0] pmask  = 3'((4'd1 << ext_psc) - 4'd1);
  wire       pevent = ext_edge_q && ((pcnt & pmask) == pmask);
  wire       tick   = ext_clk_en ? pevent : 1'b1;
  wire       freeze = dbg_halt & dbg_stop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt        <= '0;
      count_o     <= '0;
      cnt_en_o    <= 1'b0;
      trig_flag_o <= 1'b0;
    end else begin
      if (ext_edge_q) pcnt <= pevent ? 3'd0 : pcnt + 3'd1;
      if (cnt_en_o && tick && !freeze) count_o <= count_o + 1'b1;
      cnt_en_o    <= (slave_mode == MODE_TRIG) ? (cnt_en_o | trig_q) : run_i;
      trig_flag_o <= trig_q | (trig_flag_o & ~flag_clr);
    end
  end

  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> trig_flag_o); // R11
  AST_TRIG_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == MODE_TRIG && trig_q) |=> cnt_en_o); // R2
  AST_ENABLE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == MODE_TRIG && cnt_en_o) |=> cnt_en_o); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en_o |=> $stable(count_o)); // R2
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && dbg_stop_en) |=> $stable(count_o)); // R10
  AST_NO_EDGE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_en && !ext_edge_q) |=> $stable(count_o)); // R6
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) + 1'b1))); // R12
endmodule

// File: tb/tb_ext_trig_counter.sv
`timescale 1ns/1ps
module tb_ext_trig_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_clk_i = 0, ch1_i = 0, ext_clk_en = 0, ext_pol = 0, trig_pol = 0;
  logic run_i = 0, dbg_halt = 0, dbg_stop_en = 0, flag_clr = 0;
  logic [1:0] ext_psc = 0;
  logic [2:0] trig_sel = 3'b101, slave_mode = 3'b000;
  logic [15:0] count_o;
  logic cnt_en_o, trig_flag_o;

  always #2 clk = ~clk;

  ext_trig_counter dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .ch1_i(ch1_i),
    .ext_clk_en(ext_clk_en), .ext_pol(ext_pol), .ext_psc(ext_psc),
    .trig_sel(trig_sel), .trig_pol(trig_pol), .slave_mode(slave_mode),
    .run_i(run_i), .dbg_halt(dbg_halt), .dbg_stop_en(dbg_stop_en),
    .flag_clr(flag_clr), .count_o(count_o), .cnt_en_o(cnt_en_o),
    .trig_flag_o(trig_flag_o));

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model: sample histories, behavioural arithmetic
  bit xh[1:4], chh[1:4];
  bit pe_prev, pt_prev;
  logic [2:0] sel_prev;
  int pc, m_cnt, dv;
  bit m_en, m_flag, model_live, ev, tr, pev, tick;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= 4; i++) begin xh[i] = 0; chh[i] = 0; end
      pe_prev = 0; pt_prev = 0; sel_prev = 0;
      pc = 0; m_cnt = 0; m_en = 0; m_flag = 0; model_live = 0;
    end else begin
      ev = pe_prev ? (!xh[3] && xh[4]) : (xh[3] && !xh[4]);
      tr = (sel_prev == 3'b101) && (pt_prev ? (!chh[3] && chh[4]) : (chh[3] && !chh[4]));
      dv = 1 << ext_psc;
      pev = ev && ((pc % dv) == dv - 1);
      if (ev) pc = pev ? 0 : (pc + 1) % 8;
      tick = ext_clk_en ? pev : 1'b1;
      if (m_en && tick && !(dbg_halt && dbg_stop_en)) m_cnt = (m_cnt + 1) % 65536;
      m_en = (slave_mode == 3'b110) ? (m_en || tr) : run_i;
      m_flag = tr || (m_flag && !flag_clr);
      for (int i = 4; i > 1; i--) begin xh[i] = xh[i-1]; chh[i] = chh[i-1]; end
      xh[1] = ext_clk_i; chh[1] = ch1_i;
      pe_prev = ext_pol; pt_prev = trig_pol; sel_prev = trig_sel;
      model_live = 1;
    end
  end

  always @(negedge clk) begin
    if (model_live && rst_n && !done) begin
      check(cur_req, "model count", int'(count_o), m_cnt);
      check(cur_req, "model enable", int'(cnt_en_o), int'(m_en));
      check(cur_req, "model flag", int'(trig_flag_o), int'(m_flag));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    ext_clk_i = 0; ch1_i = 0; rst_n = 0;
    cyc(2);
    rst_n = 1;
    cyc(2);
  endtask

  task automatic ext_pulses(int n);
    repeat (n) begin ext_clk_i = 1; cyc(2); ext_clk_i = 0; cyc(2); end
  endtask

  task automatic ch_pulse();
    ch1_i = 1; cyc(2); ch1_i = 0; cyc(4);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    cyc(3);
    check("R1", "reset count", int'(count_o), 0);
    check("R1", "reset enable", int'(cnt_en_o), 0);
    check("R1", "reset flag", int'(trig_flag_o), 0);
    rst_n = 1; cyc(2);

    cur_req = "R8"; slave_mode = 3'b000; ext_clk_en = 0; run_i = 1;
    cyc(10);
    check("R8", "internal count", int'(count_o), 9);
    cur_req = "R9"; run_i = 0; cyc(2);
    check("R9", "enable follows run low", int'(cnt_en_o), 0);
    run_i = 1; cyc(1);
    check("R9", "enable follows run high", int'(cnt_en_o), 1);
    run_i = 0;

    cur_req = "R2"; do_reset();
    slave_mode = 3'b110; trig_sel = 3'b101; ext_clk_en = 1; ext_psc = 0;
    ext_pulses(5); cyc(4);
    check("R2", "idle before trigger", int'(count_o), 0);
    check("R2", "no enable before trigger", int'(cnt_en_o), 0);
    ch1_i = 1; cyc(3);
    check("R2", "enable not early", int'(cnt_en_o), 0);
    cyc(1);
    check("R2", "enable at edge+3", int'(cnt_en_o), 1);
    check("R2", "flag at edge+3", int'(trig_flag_o), 1);
    ch1_i = 0; cyc(4);

    cur_req = "R6"; ext_pulses(10); cyc(5);
    check("R6", "rising ext edges", int'(count_o), 10);
    ext_pol = 1; cyc(2);
    ext_pulses(5); cyc(5);
    check("R6", "falling ext edges", int'(count_o), 15);
    ext_pol = 0; cyc(2);

    cur_req = "R5"; ch_pulse(); ch_pulse(); cyc(4);
    check("R5", "enable kept after retrigger", int'(cnt_en_o), 1);

    cur_req = "R3"; do_reset();
    trig_sel = 3'b100; ch_pulse(); trig_sel = 3'b111; ch_pulse(); cyc(4);
    check("R3", "other source no enable", int'(cnt_en_o), 0);
    check("R3", "other source no flag", int'(trig_flag_o), 0);
    trig_sel = 3'b101;

    cur_req = "R4"; do_reset();
    trig_pol = 1; cyc(2);
    ch1_i = 1; cyc(6);
    check("R4", "rising ignored when falling selected", int'(cnt_en_o), 0);
    ch1_i = 0; cyc(6);
    check("R4", "falling edge enables", int'(cnt_en_o), 1);
    check("R4", "falling edge flags", int'(trig_flag_o), 1);
    trig_pol = 0;

    cur_req = "R7";
    for (int p = 1; p < 4; p++) begin
      do_reset();
      ext_psc = 2'(p);
      ch_pulse(); cyc(2);
      ext_pulses(16); cyc(5);
      check("R7", $sformatf("prescale %0d", p), int'(count_o), 16 >> p);
    end
    ext_psc = 0;

    cur_req = "R10"; do_reset();
    slave_mode = 3'b000; ext_clk_en = 0; run_i = 1; cyc(5);
    dbg_halt = 1; dbg_stop_en = 1; c0 = int'(count_o);
    cyc(20);
    check("R10", "frozen while halted", int'(count_o), c0);
    dbg_stop_en = 0; c0 = int'(count_o);
    cyc(10);
    check("R10", "halt ignored without stop", int'(count_o), c0 + 10);
    dbg_halt = 0; run_i = 0;

    cur_req = "R11"; do_reset();
    slave_mode = 3'b110; ch_pulse(); cyc(2);
    flag_clr = 1; cyc(1); flag_clr = 0;
    check("R11", "clear pulse", int'(trig_flag_o), 0);
    ch1_i = 1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    check("R11", "set wins over clear", int'(trig_flag_o), 1);
    ch1_i = 0; cyc(6);
    check("R11", "flag sticky", int'(trig_flag_o), 1);

    cur_req = "R12"; do_reset();
    slave_mode = 3'b000; ext_clk_en = 0; run_i = 1;
    for (int i = 0; i < 70000 && count_o != 16'hFFFF; i++) cyc(1);
    check("R12", "reached max", int'(count_o), 65535);
    cyc(1);
    check("R12", "wrap to zero", int'(count_o), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule